// File: doc/BRIEF.md
# Negative Cycle Detector and Tracer

This block runs after a shortest-path relaxation pass has settled a table of vertex distances. It sweeps every edge of the weighted graph once, looking for an edge that could still shorten a distance. The first such edge proves that a negative-weight cycle exists. Starting at that edge's destination, the block follows the stored predecessor links and sets a visited flag on each vertex it passes. When it lands on a vertex that is already flagged, that vertex lies on the cycle.

From that vertex the block walks the cycle once more. It emits each member as a character write to a text frame buffer, placing the members side by side on one row. With weights stored as negated logarithms of exchange rates, the printed loop is a chain of conversions whose product of rates exceeds one.

The adjacency RAM and the vertex RAM sit outside the block. Both have a one-cycle synchronous read. Each vertex word holds three fields, from the top bit down: the visited flag, the predecessor index and a two's-complement distance.

Top module: `negcycle_tracer`

## Requirements
- R1: While `rstN` is low and after its release, `done`, `frameWe` and `vtxWeA` are 0 until a run is started.
- R2: A pulse on `start` sweeps the edges with the source index as the outer loop and the destination index as the inner loop. An edge is relaxable when the source distance is not INF, the weight is not INF, and the signed sum of source distance and weight is less than the destination distance. INF is the largest positive DW-bit value, and an INF weight means there is no edge. Only the first relaxable edge in sweep order starts a trace.
- R3: If no edge is relaxable, the block raises `done` with `noCycle`=1. It makes no frame write and no vertex write.
- R4: The trace reads the current vertex. If the visited flag (bit VW-1) is clear, it writes the word back with the flag set and with the predecessor field [VW-2:DW] and the distance field [DW-1:0] unchanged. It then moves to the predecessor.
- R5: The first vertex read with its flag already set ends the trace and becomes the cycle entry.
- R6: The print phase emits one frame write per cycle member, starting at the entry and following predecessors, and stops before the entry would repeat. Each write carries the vertex index as `frameChar`, x positions 0, 1, 2 and so on, and `frameY` = FRAME_ROW. The run then ends with `done`=1 and `noCycle`=0.
- R7: If the trace meets a predecessor index of NUM_V or more, or has already marked NUM_V vertices, it is abandoned. The block raises `done` with `noCycle`=1, and there is no frame write and no further vertex write.
- R8: `done` and `noCycle` hold until the next `start`. A `start` pulse during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle or finished |
| done | output | 1 | Run finished; held until next start |
| noCycle | output | 1 | With `done`: no cycle found, or trace abandoned |
| adjRow | output | AW | Adjacency RAM row address (edge source) |
| adjCol | output | AW | Adjacency RAM column address (edge destination) |
| adjQ | input | DW | Edge weight read data, signed; INF means no edge |
| vtxAddrA | output | AW | Vertex RAM port A address (read and write) |
| vtxQA | input | 1+AW+DW | Vertex RAM port A read data |
| vtxWeA | output | 1 | Vertex RAM port A write enable |
| vtxDataA | output | 1+AW+DW | Vertex RAM port A write data |
| vtxAddrB | output | AW | Vertex RAM port B read address (edge destination) |
| vtxQB | input | 1+AW+DW | Vertex RAM port B read data |
| frameWe | output | 1 | Frame buffer write strobe |
| frameChar | output | CW | Character code: the vertex index |
| frameX | output | XW | Column of the character |
| frameY | output | XW | Row of the character |

## Verification
The bench builds the block with NUM_V=6, AW=3 and FRAME_ROW=2. With these values a full sweep takes 36 edges, so a scenario with no relaxable edge runs to the end of the sweep quickly. A ring through every vertex pushes the trace to its full step count. The 3-bit index also leaves predecessor codes 6 and 7 free as out-of-range values, which brings the abandon path within reach. A non-zero row exposes a `frameY` that is dropped or miswired.

// File: rtl/ncd_pkg.sv
package ncd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SWEEP, S_TR_RD, S_TR_EV, S_PR_RD, S_PR_EV, S_DONE
  } phase_e;

  // Control to datapath strobes
  typedef struct packed {
    logic clear;
    logic sweep;
    logic traceLoad;
    logic traceMark;
    logic traceAdv;
    logic printLoad;
    logic printEmit;
  } strobe_t;

  // Datapath to control status
  typedef struct packed {
    logic hit;
    logic sweepEnd;
    logic flagged;
    logic predBad;
    logic stepLimit;
    logic predIsEntry;
  } status_t;

endpackage

// File: rtl/ncd_dpath.sv
module ncd_dpath
  import ncd_pkg::*;
#(
  parameter int NUM_V     = 33,
  parameter int AW        = 7,
  parameter int DW        = 32,
  parameter int CW        = 6,
  parameter int XW        = 6,
  parameter int FRAME_ROW = 0,
  localparam int VW       = 1 + AW + DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  output status_t       sts,
  output logic [AW-1:0] adjRow,
  output logic [AW-1:0] adjCol,
  input  logic [DW-1:0] adjQ,
  output logic [AW-1:0] vtxAddrA,
  input  logic [VW-1:0] vtxQA,
  output logic          vtxWeA,
  output logic [VW-1:0] vtxDataA,
  output logic [AW-1:0] vtxAddrB,
  input  logic [VW-1:0] vtxQB,
  output logic          frameWe,
  output logic [CW-1:0] frameChar,
  output logic [XW-1:0] frameX,
  output logic [XW-1:0] frameY
);
  localparam int SW = $clog2(NUM_V + 1);
  localparam logic [DW-1:0] INF = {1'b0, {(DW-1){1'b1}}};
  localparam logic [AW-1:0] LAST_V = AW'(NUM_V - 1);

  logic [AW-1:0] srcIdx, dstIdx, pendDst, curV, entryV;
  logic          exhausted, pendValid, pendLast;
  logic [XW-1:0] xPos;
  logic [SW-1:0] stepCnt;

  logic [DW-1:0] srcDist, dstDist;
  logic [AW-1:0] predOfA;
  logic [DW:0]   sumExt;
  logic          unusedQB;

  assign srcDist  = vtxQA[DW-1:0];
  assign dstDist  = vtxQB[DW-1:0];
  assign predOfA  = vtxQA[VW-2:DW];
  assign unusedQB = ^vtxQB[VW-1:DW];
  assign sumExt   = {srcDist[DW-1], srcDist} + {adjQ[DW-1], adjQ};

  always_comb begin
    sts.hit = pendValid && (srcDist != INF) && (adjQ != INF) &&
              ($signed(sumExt) < $signed({dstDist[DW-1], dstDist}));
    sts.sweepEnd    = pendValid && pendLast;
    sts.flagged     = vtxQA[VW-1];
    sts.predBad     = {1'b0, predOfA} >= (AW+1)'(NUM_V);
    sts.stepLimit   = stepCnt == SW'(NUM_V);
    sts.predIsEntry = predOfA == entryV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcIdx <= '0; dstIdx <= '0; pendDst <= '0; curV <= '0; entryV <= '0;
      exhausted <= 1'b0; pendValid <= 1'b0; pendLast <= 1'b0;
      xPos <= '0; stepCnt <= '0;
    end else begin
      if (stb.clear) begin
        srcIdx <= '0; dstIdx <= '0; exhausted <= 1'b0;
        pendValid <= 1'b0; pendLast <= 1'b0; xPos <= '0; stepCnt <= '0;
      end else if (stb.sweep) begin
        pendValid <= !exhausted;
        pendDst   <= dstIdx;
        pendLast  <= (srcIdx == LAST_V) && (dstIdx == LAST_V);
        if (!exhausted) begin
          if (dstIdx == LAST_V) begin
            dstIdx <= '0;
            if (srcIdx == LAST_V) exhausted <= 1'b1;
            else                  srcIdx <= srcIdx + 1'b1;
          end else begin
            dstIdx <= dstIdx + 1'b1;
          end
        end
      end
      if (stb.traceLoad) begin
        curV <= pendDst;
        stepCnt <= '0;
      end
      if (stb.traceAdv) begin
        curV <= predOfA;
        stepCnt <= stepCnt + 1'b1;
      end
      if (stb.printLoad) entryV <= curV;
      if (stb.printEmit) begin
        curV <= predOfA;
        xPos <= xPos + 1'b1;
      end
    end
  end

  assign adjRow    = srcIdx;
  assign adjCol    = dstIdx;
  assign vtxAddrA  = stb.sweep ? srcIdx : curV;
  assign vtxAddrB  = dstIdx;
  assign vtxWeA    = stb.traceMark;
  assign vtxDataA  = {1'b1, vtxQA[VW-2:0]};
  assign frameWe   = stb.printEmit;
  assign frameChar = CW'(curV);
  assign frameX    = xPos;
  assign frameY    = XW'(FRAME_ROW);

endmodule

// File: rtl/ncd_ctrl.sv
module ncd_ctrl
  import ncd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  status_t sts,
  output strobe_t stb,
  output logic    done,
  output logic    noCycle
);
  phase_e state, nextState;
  logic   setNo;

  always_comb begin
    stb       = '0;
    setNo     = 1'b0;
    nextState = state;
    case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          stb.clear = 1'b1;
          nextState = S_SWEEP;
        end
      end
      S_SWEEP: begin
        stb.sweep = 1'b1;
        if (sts.hit) begin
          stb.traceLoad = 1'b1;
          nextState     = S_TR_RD;
        end else if (sts.sweepEnd) begin
          setNo     = 1'b1;
          nextState = S_DONE;
        end
      end
      S_TR_RD: nextState = S_TR_EV;
      S_TR_EV: begin
        if (sts.flagged) begin
          stb.printLoad = 1'b1;
          nextState     = S_PR_RD;
        end else if (sts.predBad || sts.stepLimit) begin
          setNo     = 1'b1;
          nextState = S_DONE;
        end else begin
          stb.traceMark = 1'b1;
          stb.traceAdv  = 1'b1;
          nextState     = S_TR_RD;
        end
      end
      S_PR_RD: nextState = S_PR_EV;
      S_PR_EV: begin
        stb.printEmit = 1'b1;
        nextState     = sts.predIsEntry ? S_DONE : S_PR_RD;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      noCycle <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.clear)  noCycle <= 1'b0;
      else if (setNo) noCycle <= 1'b1;
    end
  end

  assign done = state == S_DONE;

endmodule

// File: rtl/negcycle_tracer.sv
module negcycle_tracer
  import ncd_pkg::*;
#(
  parameter int NUM_V     = 33,
  parameter int AW        = 7,
  parameter int DW        = 32,
  parameter int CW        = 6,
  parameter int XW        = 6,
  parameter int FRAME_ROW = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  output logic               done,
  output logic               noCycle,
  output logic [AW-1:0]      adjRow,
  output logic [AW-1:0]      adjCol,
  input  logic [DW-1:0]      adjQ,
  output logic [AW-1:0]      vtxAddrA,
  input  logic [AW+DW:0]     vtxQA,
  output logic               vtxWeA,
  output logic [AW+DW:0]     vtxDataA,
  output logic [AW-1:0]      vtxAddrB,
  input  logic [AW+DW:0]     vtxQB,
  output logic               frameWe,
  output logic [CW-1:0]      frameChar,
  output logic [XW-1:0]      frameX,
  output logic [XW-1:0]      frameY
);
  strobe_t stb;
  status_t sts;

  ncd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sts(sts),
    .stb(stb), .done(done), .noCycle(noCycle)
  );

  ncd_dpath #(
    .NUM_V(NUM_V), .AW(AW), .DW(DW), .CW(CW), .XW(XW), .FRAME_ROW(FRAME_ROW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sts(sts),
    .adjRow(adjRow), .adjCol(adjCol), .adjQ(adjQ),
    .vtxAddrA(vtxAddrA), .vtxQA(vtxQA), .vtxWeA(vtxWeA), .vtxDataA(vtxDataA),
    .vtxAddrB(vtxAddrB), .vtxQB(vtxQB),
    .frameWe(frameWe), .frameChar(frameChar), .frameX(frameX), .frameY(frameY)
  );

endmodule

// File: rtl/negcycle_tracer_chk.sv
module negcycle_tracer_chk #(
  parameter int AW        = 7,
  parameter int DW        = 32,
  parameter int XW        = 6,
  parameter int FRAME_ROW = 0
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          done,
  input logic          noCycle,
  input logic          vtxWeA,
  input logic [AW+DW:0] vtxQA,
  input logic [AW+DW:0] vtxDataA,
  input logic          frameWe,
  input logic [XW-1:0] frameX,
  input logic [XW-1:0] frameY
);
  logic          seenX;
  logic [XW-1:0] lastX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenX <= 1'b0;
      lastX <= '0;
    end else if (done) begin
      seenX <= 1'b0;
    end else if (frameWe) begin
      seenX <= 1'b1;
      lastX <= frameX;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !done && !frameWe && !vtxWeA);

  p_done_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !frameWe && !vtxWeA);

  p_mark_keeps_fields_r4: assert property (@(posedge clk) disable iff (!rstN)
    vtxWeA |-> !vtxQA[AW+DW] && vtxDataA[AW+DW] &&
               (vtxDataA[AW+DW-1:0] == vtxQA[AW+DW-1:0]));

  p_row_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameWe |-> frameY == XW'(FRAME_ROW));

  p_x_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameWe && !seenX |-> frameX == '0);

  p_x_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameWe && seenX |-> frameX == XW'(lastX + 1'b1));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(noCycle));

endmodule

bind negcycle_tracer negcycle_tracer_chk #(
  .AW(AW), .DW(DW), .XW(XW), .FRAME_ROW(FRAME_ROW)
) u_chk (.*);

// File: tb/sim_negcycle_tracer.sv
`timescale 1ns/1ps
module sim_negcycle_tracer;
  localparam int NV = 6, AW = 3, DW = 32, CW = 6, XW = 6, ROW = 2;
  localparam int VW = 1 + AW + DW;
  localparam logic [DW-1:0] INF = {1'b0, {(DW-1){1'b1}}};

  typedef struct packed {
    logic [2:0] s1, d1;
    logic signed [7:0] w1;
    logic       hasS2;
    logic [2:0] s2, d2;
    logic [17:0] preds;   // {p5,p4,p3,p2,p1,p0}
    logic       infUsed;
    logic [2:0] infV;
    logic       expNo;
    logic [2:0] expEntry;
    logic [3:0] expLen;
  } case_t;

  localparam int NC = 6;
  localparam case_t CASES [NC] = '{
    '{3'd0,3'd3,-8'sd1,1'b0,3'd0,3'd0,{3'd3,3'd5,3'd4,3'd0,3'd0,3'd0},1'b0,3'd0,1'b0,3'd3,4'd3},
    '{3'd2,3'd1,-8'sd1,1'b0,3'd0,3'd0,{3'd0,3'd0,3'd0,3'd0,3'd2,3'd4},1'b0,3'd0,1'b0,3'd0,4'd2},
    '{3'd5,3'd5,-8'sd1,1'b0,3'd0,3'd0,{3'd5,3'd0,3'd0,3'd0,3'd0,3'd0},1'b0,3'd0,1'b0,3'd5,4'd1},
    '{3'd0,3'd1, 8'sd0,1'b1,3'd3,3'd4,{3'd0,3'd0,3'd0,3'd0,3'd0,3'd0},1'b1,3'd3,1'b1,3'd0,4'd0},
    '{3'd1,3'd2,-8'sd1,1'b0,3'd0,3'd0,{3'd0,3'd0,3'd0,3'd7,3'd0,3'd0},1'b0,3'd0,1'b1,3'd0,4'd0},
    '{3'd1,3'd5,-8'sd1,1'b1,3'd3,3'd4,{3'd0,3'd5,3'd4,3'd3,3'd2,3'd1},1'b0,3'd0,1'b0,3'd5,4'd6}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic done, noCycle, vtxWeA, frameWe;
  logic [AW-1:0] adjRow, adjCol, vtxAddrA, vtxAddrB;
  logic [DW-1:0] adjQ;
  logic [VW-1:0] vtxQA, vtxQB, vtxDataA;
  logic [CW-1:0] frameChar;
  logic [XW-1:0] frameX, frameY;

  always #4 clk = ~clk;

  negcycle_tracer #(.NUM_V(NV), .AW(AW), .DW(DW), .CW(CW), .XW(XW), .FRAME_ROW(ROW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .noCycle(noCycle),
    .adjRow(adjRow), .adjCol(adjCol), .adjQ(adjQ),
    .vtxAddrA(vtxAddrA), .vtxQA(vtxQA), .vtxWeA(vtxWeA), .vtxDataA(vtxDataA),
    .vtxAddrB(vtxAddrB), .vtxQB(vtxQB),
    .frameWe(frameWe), .frameChar(frameChar), .frameX(frameX), .frameY(frameY));

  // Memory models: one-cycle synchronous read
  logic [DW-1:0] adjMem [8][8];
  logic [VW-1:0] vtxMem [8];
  logic [VW-1:0] origMem [8];
  always @(posedge clk) begin
    adjQ  <= adjMem[adjRow][adjCol];
    vtxQA <= vtxMem[vtxAddrA];
    vtxQB <= vtxMem[vtxAddrB];
    if (vtxWeA) vtxMem[vtxAddrA] <= vtxDataA;
  end

  int fwCount = 0;
  logic [CW-1:0] capChar [16];
  logic [XW-1:0] capX [16], capY [16];
  always @(negedge clk) begin
    if (frameWe && fwCount < 16) begin
      capChar[fwCount] = frameChar;
      capX[fwCount] = frameX;
      capY[fwCount] = frameY;
    end
    if (frameWe) fwCount++;
  end

  int tests = 0, fails = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    tests++;
    $display("FAIL watchdog R8 actual=0 expected=1");
    finishRun();
  end

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic runCase(input case_t c, input logic midStart, input int idx);
    logic [2:0] pr [8];
    logic       expFlag [8];
    int v, waitCnt, bad;
    for (int k = 0; k < 8; k++) begin
      pr[k] = (k < NV) ? c.preds[3*k +: 3] : 3'd0;
      for (int m = 0; m < 8; m++) adjMem[k][m] = INF;
      vtxMem[k] = (k < NV) ? {1'b0, pr[k], DW'(0)} : '0;
      if (c.infUsed && k == int'(c.infV)) vtxMem[k][DW-1:0] = INF;
      origMem[k] = vtxMem[k];
      expFlag[k] = 1'b0;
    end
    adjMem[c.s1][c.d1] = {{(DW-8){c.w1[7]}}, c.w1};
    if (c.hasS2) adjMem[c.s2][c.d2] = {DW{1'b1}};
    fwCount = 0;
    pulseStart();
    if (midStart) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done, $sformatf("R8 case%0d done reached", idx), int'(done), 1);
    check(noCycle == c.expNo, $sformatf("R2/R3/R7 case%0d noCycle", idx), int'(noCycle), int'(c.expNo));
    check(fwCount == int'(c.expLen), $sformatf("R6 case%0d frame write count", idx), fwCount, int'(c.expLen));
    if (!c.expNo && fwCount == int'(c.expLen)) begin
      v = int'(c.expEntry);
      check(capChar[0] == CW'(c.expEntry), $sformatf("R5 case%0d entry", idx), int'(capChar[0]), v);
      bad = 0;
      for (int k = 0; k < fwCount; k++) begin
        if (capChar[k] != CW'(v) || capX[k] != XW'(k) || capY[k] != XW'(ROW)) bad++;
        v = int'(pr[v]);
      end
      check(bad == 0, $sformatf("R6 case%0d char/x/y sequence mismatches", idx), bad, 0);
      v = int'(c.d1);
      while (!expFlag[v]) begin
        expFlag[v] = 1'b1;
        v = int'(pr[v]);
      end
    end
    bad = 0;
    for (int k = 0; k < NV; k++)
      if (vtxMem[k] != {expFlag[k], origMem[k][VW-2:0]}) bad++;
    check(bad == 0, $sformatf("R4 case%0d vertex words after trace", idx), bad, 0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      vtxMem[k] = '0;
      for (int m = 0; m < 8; m++) adjMem[k][m] = INF;
    end
    repeat (3) @(negedge clk);
    check(!done && !frameWe && !vtxWeA, "R1 outputs in reset", int'(done), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !frameWe && !vtxWeA, "R1 idle after reset", int'(done), 0);

    for (int i = 0; i < NC; i++) runCase(CASES[i], 1'b0, i);

    // R8: done and noCycle hold with no start
    repeat (6) @(negedge clk);
    check(done && !noCycle, "R8 done held after ring case", int'(done), 1);

    // R8: start during the sweep does not disturb the run
    runCase(CASES[5], 1'b1, 10);

    // R3 after a cycle run: noCycle cleared by next start, then set again
    runCase(CASES[3], 1'b0, 11);

    finishRun();
  end

endmodule